// File: doc/BRIEF.md
# Multi-mode timer counter core

This block is a 16-bit timer counter. Its counting clock is one of four clock-enable inputs, picked by a source field. A prescaler of 1, 2, 4 or 8 sits between that enable and the count. A mode field picks one of four behaviours: halted, counting up to a programmable period, free-running over the full range, or a triangle that climbs to the period and falls back to zero.

Software drives a simple write port. Address 0 holds a control word and address 1 holds the period. Writing the control word with its clear bit set resets the count, the prescaler and the triangle direction on the same edge. A pending flag is raised each time the count returns to zero. When it is enabled, that flag drives the interrupt request.

The block brings out three things: the current count, a one-cycle strobe for the tick on which the count equals the period, and the flag.

Top module: `tmr_core`

## Requirements
- R1: After reset, count, flag and irq are 0 and the mode is halted.
- R2: The control word bits [1:0] select which clk_en bit advances the prescaler. Enables on other bits have no effect on count.
- R3: The control word bits [3:2] set the divider to 2^value. The count takes one step per that many selected enables, and a clear restarts the division.
- R4: Mode 00 in control bits [5:4] holds the count unchanged.
- R5: In mode 01, the count steps 0,1,...,period, then goes to 0 on the next tick. A period of 0 keeps the count at 0.
- R6: In mode 10, the count steps up to 0xFFFF and then wraps to 0.
- R7: In mode 11, the count climbs to the period and then falls back to 0, one step per tick. For period 3 the sequence is 0,1,2,3,2,1,0,1,...
- R8: A control write with bit 6 set forces the count to 0, clears the prescaler and restores the upward direction on that write edge. It also suppresses any zero-return event on that edge.
- R9: The flag is set by a return to zero: the wrap in modes 01 and 10, or the step from 1 to 0 going down in mode 11. Otherwise a control write loads the flag from bit 8. The event wins over the write.
- R10: irq equals the flag while control bit 7 is 1, and is 0 otherwise.
- R11: period_hit is high for exactly the cycles in which a counting tick occurs while count equals the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 4 | Candidate counting clock enables |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control word, 1 selects the period |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current count |
| period_hit | output | 1 | Tick while count equals the period |
| flag | output | 1 | Zero-return pending flag |
| irq | output | 1 | Interrupt request |

## Verification
A register write and any clear take effect on the edge that samples wr_en. New control fields first govern the tick on the edge after that. A counting tick changes count and flag on the edge where the selected enable is sampled. period_hit and irq are combinational and are due in the same cycle as the state they depend on. The behavioural model steps on each rising edge and is compared a quarter period later. The directed checks drive inputs at falling edges and read results at the falling edge that follows the last counted edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SRC_W  = 2;
  localparam int DIV_W  = 2;
  localparam int PRE_W  = (1 << DIV_W) - 1;
  localparam int SRC_LSB  = 0;
  localparam int DIV_LSB  = 2;
  localparam int MODE_LSB = 4;
  localparam int CLR_BIT  = 6;
  localparam int IE_BIT   = 7;
  localparam int FLAG_BIT = 8;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_PER  = 1'b1;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_CONT = 2'd2,
    MODE_TRI  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
    tmr_mode_e        mode;
    logic             ie;
  } tmr_ctrl_t;

  // prescaler terminal value for a divide-by-2^d setting
  function automatic logic [PRE_W-1:0] div_limit(input logic [DIV_W-1:0] d);
    return PRE_W'((1 << d) - 1);
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             evt,
  output tmr_ctrl_t        ctrl_q,
  output logic [CNT_W-1:0] period_q,
  output logic             clr_cmd,
  output logic             flag_q
);
  logic ctrl_wr;
  logic per_wr;

  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
  assign per_wr  = wr_en && (wr_addr == ADDR_PER);
  // the clear bit is a command only; it is never stored
  assign clr_cmd = ctrl_wr && wr_data[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q.src  <= wr_data[SRC_LSB +: SRC_W];
      ctrl_q.div  <= wr_data[DIV_LSB +: DIV_W];
      ctrl_q.mode <= tmr_mode_e'(wr_data[MODE_LSB +: 2]);
      ctrl_q.ie   <= wr_data[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_q <= '0;
    else if (per_wr) period_q <= wr_data;
  end

  // a zero-return event wins over a software write of the flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (evt) flag_q <= 1'b1;
    else if (ctrl_wr) flag_q <= wr_data[FLAG_BIT];
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] clk_en,
  input  logic [SRC_W-1:0]   src,
  input  logic [DIV_W-1:0]   div,
  input  logic               run,
  input  logic               clr,
  output logic               tick
);
  logic [NUM_SRC-1:0] pick;
  logic               sel_en;
  logic [PRE_W-1:0]   pcnt;
  logic [PRE_W-1:0]   limit;
  logic               at_lim;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
    assign pick[g] = clk_en[g] && (src == SRC_W'(g));
  end

  assign sel_en = |pick;
  assign limit  = div_limit(div);
  assign at_lim = (pcnt >= limit);
  assign tick   = run && sel_en && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else if (clr) pcnt <= '0;
    else if (run && sel_en) pcnt <= at_lim ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  tmr_mode_e        mode,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             period_hit,
  output logic             evt
);
  typedef struct packed {
    logic [CNT_W-1:0] cnt;
    logic             dn;
    logic             zret;
  } step_t;

  // one counting step for the given mode
  function automatic step_t step_fn(input logic [CNT_W-1:0] c,
                                    input logic [CNT_W-1:0] p,
                                    input logic d, input tmr_mode_e m);
    step_t s;
    s.cnt = c; s.dn = d; s.zret = 1'b0;
    case (m)
      MODE_UP: begin
        s.dn = 1'b0;
        if (c >= p) begin s.cnt = '0; s.zret = 1'b1; end
        else s.cnt = c + 1'b1;
      end
      MODE_CONT: begin
        s.dn   = 1'b0;
        s.cnt  = c + 1'b1;
        s.zret = (c == {CNT_W{1'b1}});
      end
      MODE_TRI: begin
        if (!d) begin
          if (c >= p) begin
            s.dn  = 1'b1;
            s.cnt = (c == '0) ? '0 : c - 1'b1;
          end else s.cnt = c + 1'b1;
        end else if (c <= CNT_W'(1)) begin
          s.cnt = '0; s.dn = 1'b0; s.zret = 1'b1;
        end else s.cnt = c - 1'b1;
      end
      default: ;
    endcase
    return s;
  endfunction

  logic  dn_q;
  step_t nxt;

  assign nxt        = step_fn(count, period, dn_q, mode);
  assign evt        = tick && !clr && nxt.zret;
  assign period_hit = tick && (count == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      dn_q  <= 1'b0;
    end else if (clr) begin
      count <= '0;
      dn_q  <= 1'b0;
    end else if (tick) begin
      count <= nxt.cnt;
      dn_q  <= nxt.dn;
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 1 << SRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] clk_en,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   count,
  output logic               period_hit,
  output logic               flag,
  output logic               irq
);
  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] period_q;
  logic             clr_cmd;
  logic             tick;
  logic             evt;
  logic             run;
  tmr_mode_e        cur_mode;
  logic [SRC_W-1:0] cur_src;

  assign cur_mode = ctrl_q.mode;
  assign cur_src  = ctrl_q.src;
  assign run      = (cur_mode != MODE_STOP);

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .evt(evt), .ctrl_q(ctrl_q), .period_q(period_q),
    .clr_cmd(clr_cmd), .flag_q(flag)
  );

  tmr_prescale #(.NUM_SRC(NUM_SRC)) u_pre (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .src(cur_src),
    .div(ctrl_q.div), .run(run), .clr(clr_cmd), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr_cmd), .mode(cur_mode),
    .period(period_q), .count(count), .period_hit(period_hit), .evt(evt)
  );

  assign irq = flag && ctrl_q.ie;
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] clk_en,
  input logic [SRC_W-1:0]   src,
  input tmr_mode_e          mode,
  input logic               tick,
  input logic               clr_cmd,
  input logic               evt,
  input logic               wr_en,
  input logic [CNT_W-1:0]   count,
  input logic [CNT_W-1:0]   period,
  input logic               flag,
  input logic               period_hit
);
  a_r3_tick_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> clk_en[src]);

  a_r4_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STOP && !clr_cmd) |=> $stable(count));

  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (count == '0));

  a_r9_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  a_r5_up_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UP && !wr_en && count <= period) |=> (count <= period));

  a_r7_tri_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TRI && !wr_en && count <= period) |=> (count <= period));

  a_r11_hit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |-> tick);
endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .src(cur_src), .mode(cur_mode),
  .tick(tick), .clr_cmd(clr_cmd), .evt(evt), .wr_en(wr_en), .count(count),
  .period(period_q), .flag(flag), .period_hit(period_hit)
);

// File: tb/tb_tmr_core.sv
module tb_tmr_core;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  clk_en = 4'b0000;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        period_hit, flag, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  tmr_core dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .period_hit(period_hit), .flag(flag), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference state
  int m_cnt, m_pre, m_dn, m_flag, m_src, m_div, m_mode, m_ie, m_per;

  function automatic bit m_tick();
    return (m_mode != 0) && clk_en[m_src] && (m_pre + 1 >= (1 << m_div));
  endfunction

  task automatic model_step();
    bit t, ev, cw_hit, clr;
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_dn = 0; m_flag = 0;
      m_src = 0; m_div = 0; m_mode = 0; m_ie = 0; m_per = 0;
      return;
    end
    t = m_tick();
    ev = 0;
    cw_hit = wr_en && !wr_addr;
    clr = cw_hit && wr_data[6];
    if (m_mode != 0 && clk_en[m_src])
      m_pre = (m_pre + 1 >= (1 << m_div)) ? 0 : m_pre + 1;
    if (t) begin
      if (m_mode == 1) begin
        m_dn = 0;
        if (m_cnt >= m_per) begin m_cnt = 0; ev = 1; end else m_cnt++;
      end else if (m_mode == 2) begin
        m_dn = 0;
        if (m_cnt == 65535) begin m_cnt = 0; ev = 1; end else m_cnt++;
      end else if (m_mode == 3) begin
        if (m_dn == 0) begin
          if (m_cnt >= m_per) begin m_dn = 1; if (m_cnt > 0) m_cnt--; end
          else m_cnt++;
        end else if (m_cnt <= 1) begin
          m_cnt = 0; m_dn = 0; ev = 1;
        end else m_cnt--;
      end
    end
    if (clr) begin m_cnt = 0; m_pre = 0; m_dn = 0; ev = 0; end
    if (ev) m_flag = 1;
    else if (cw_hit) m_flag = wr_data[8];
    if (cw_hit) begin
      m_src = wr_data[1:0]; m_div = wr_data[3:2];
      m_mode = wr_data[5:4]; m_ie = wr_data[7];
    end
    if (wr_en && wr_addr) m_per = wr_data;
  endtask

  always @(posedge clk) begin
    model_step();
    #(CLK_P/4);
    if (!done) begin
      chk("R5 count vs model", count, m_cnt);
      chk("R9 flag vs model", flag, m_flag);
      chk("R10 irq vs model", irq, m_flag & m_ie);
      chk("R11 hit vs model", period_hit, m_tick() && (m_cnt == m_per));
    end
  end

  function automatic logic [15:0] cw(input int src, input int dv, input int md,
                                     input bit clr, input bit ie, input bit fl);
    return 16'({fl, ie, clr, md[1:0], dv[1:0], src[1:0]});
  endfunction

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    int held;
    run(3);
    rst_n = 1'b1;
    run(1);
    chk("R1 reset count", count, 0);
    chk("R1 reset flag", flag, 0);
    chk("R1 reset irq", irq, 0);

    // R2: only the selected enable counts
    clk_en = 4'b0001;
    wr(1'b0, cw(1, 0, 1, 1, 0, 0));
    wr(1'b1, 16'd100);
    run(10);
    chk("R2 unselected enable ignored", count, 0);
    clk_en = 4'b0010;
    run(5);
    chk("R2 selected enable counts", count, 5);

    // R3: divide by 4
    clk_en = 4'b1111;
    wr(1'b0, cw(0, 2, 1, 1, 0, 0));
    run(12);
    chk("R3 divide by four", count, 3);

    // R5: up mode with period 3
    wr(1'b1, 16'd3);
    wr(1'b0, cw(0, 0, 1, 1, 0, 0));
    run(9);
    chk("R5 up wrap", count, 1);
    chk("R9 flag after wrap", flag, 1);
    chk("R10 irq masked", irq, 0);

    // R10 / R9 / R4 in halted mode
    wr(1'b0, cw(0, 0, 0, 0, 1, 1));
    chk("R10 irq enabled", irq, 1);
    wr(1'b0, cw(0, 0, 0, 0, 1, 0));
    chk("R9 flag cleared by write", flag, 0);
    chk("R10 irq follows flag", irq, 0);
    held = count;
    run(10);
    chk("R4 halted holds", count, held);

    // R5: period zero
    wr(1'b1, 16'd0);
    wr(1'b0, cw(0, 0, 1, 1, 0, 0));
    run(5);
    chk("R5 period zero stays", count, 0);

    // R7: triangle, period 3
    wr(1'b1, 16'd3);
    wr(1'b0, cw(0, 0, 3, 1, 0, 0));
    run(5);
    chk("R7 triangle falling", count, 1);
    run(1);
    chk("R7 triangle bottom", count, 0);
    chk("R9 flag at triangle bottom", flag, 1);
    run(2);
    chk("R7 triangle rising again", count, 2);
    chk("R11 hit low off period", period_hit, 0);
    run(1);
    chk("R11 hit at period", period_hit, 1);
    run(1);
    chk("R7 turned downward", count, 2);

    // R8: clear while counting down
    wr(1'b0, cw(0, 0, 3, 1, 0, 1));
    chk("R8 clear zeroes count", count, 0);
    run(1);
    chk("R8 direction back to up", count, 1);

    // R8: clear restarts the prescaler
    wr(1'b0, cw(0, 1, 1, 0, 0, 0));
    run(1);
    wr(1'b0, cw(0, 1, 1, 1, 0, 0));
    run(1);
    chk("R8 prescaler cleared", count, 0);
    run(1);
    chk("R8 prescaler restart tick", count, 1);

    // R6: continuous wrap
    wr(1'b0, cw(0, 0, 2, 1, 0, 0));
    run(65535);
    chk("R6 reaches top", count, 65535);
    chk("R6 no flag before wrap", flag, 0);
    run(1);
    chk("R6 wraps to zero", count, 0);
    chk("R6 flag on wrap", flag, 1);

    finish_up();
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      finish_up();
    end
  end
endmodule